// File: doc/BRIEF.md
# Fused Add-Multiply Datapath

This block computes the signed product of a multiplicand `x` and the sum of two addends `a` and `b`, all of them two's complement values `N` bits wide. No carry-propagate adder forms `a + b`. Each pair of addend bit columns is fed to a small recoding cell made of signed half adders and a full adder. The cell emits one radix-4 Booth digit of the sum straight away. Its carries travel only to the next cell, so the recoding depth does not depend on `N`.

The digits select 0, ±x or ±2x for each partial-product row. These rows, a row of negation bits and a constant sign-extension row go into a Wallace carry-save tree. A single parallel-prefix adder then resolves the last sum/carry pair. The result is `2N+1` bits wide, which holds every possible product without loss. When `REG_OUT` is 1, one output register follows the adder.

Top module: `fam_unit`

## Requirements
- R1: `z` equals the exact signed product `x * (a + b)`, written as a `2N+1`-bit two's complement value. With `REG_OUT` = 1 it shows the operands sampled at the previous rising clock edge.
- R2: While `rst_n` is low, `z` reads all zeros. The reset is asynchronous and active low.
- R3: The sum `a + b` is recoded into `N/2+1` radix-4 digits. Digit j has weight 4^j. Each digit is encoded as three flags {neg, two, one}. At most one of `one` and `two` is set, and `neg` is set only when the magnitude is nonzero. The weighted sum of the digits equals `a + b`.
- R4: When `a + b` leaves the `N`-bit range, the product is still exact. Examples are both addends at their largest value, or both at their most negative value.
- R5: When `x` and both addends are at their most negative value, `z` is the positive value 2^(2N-1).
- R6: When `x` is zero, or when `b` equals `-a`, `z` is zero.
- R7: Modulo 2^(2N+1), the carry-save tree's sum and carry outputs add up to the total of all rows fed into it. That total equals the product.
- R8: A new operand set is accepted every cycle and its result appears one cycle later. While the operands are held steady, `z` holds steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| x | input | N | Signed multiplicand |
| a | input | N | First signed addend |
| b | input | N | Second signed addend |
| z | output | 2N+1 | Signed product x·(a+b) |

## Verification
A small copy of the unit, with `N` = 4, is driven through every combination of its three operands. That covers every digit pattern the recoding cells can produce, including the carries between cells, so an error in any signed adder's truth table shows up. At `N` = 16, a directed table covers a sum above the positive limit, a sum below the negative limit, the most negative multiplicand, and cancelling addends. These cases separate faults in the top recoding digit and in the sign-extension constant from faults in the ordinary rows. Random operand sets applied back to back show that each result lines up with its own operands. Holding the operands and pulsing reset in the middle of traffic exercises the output register.

// File: rtl/fam_pkg.sv
`timescale 1ns/1ps
package fam_pkg;

  // One radix-4 digit: value = (neg ? -1 : 1) * (two ? 2 : one ? 1 : 0)
  typedef struct packed {
    logic neg;
    logic two;
    logic one;
  } booth_dig_t;

  // Outputs of one sum-recoding cell
  typedef struct packed {
    logic nbit;      // negatively weighted bit (weight -2 in the digit)
    logic pbit;      // positively weighted bit (weight +1 in the digit)
    logic carry_fa;  // positive carry into the next cell's full adder
    logic carry_bt;  // positive carry that becomes the next digit's low bit
  } cell_out_t;

  // a_hi+b_hi = 2*ch - sh (signed half adder, negative sum)
  // a_lo+b_lo+cin = 2*fc + fs (ordinary full adder)
  // fc - sh = 2*cb - nb (half adder with one negative input)
  function automatic cell_out_t sum_cell(input logic a_lo, input logic b_lo,
                                         input logic a_hi, input logic b_hi,
                                         input logic cin);
    cell_out_t o;
    logic sh, fc;
    sh         = a_hi ^ b_hi;
    fc         = (a_lo & b_lo) | (a_lo & cin) | (b_lo & cin);
    o.carry_fa = a_hi | b_hi;
    o.pbit     = a_lo ^ b_lo ^ cin;
    o.nbit     = sh ^ fc;
    o.carry_bt = fc & ~sh;
    return o;
  endfunction

  // Digit from triple (n, p1, p0): value = -2n + p1 + p0
  function automatic booth_dig_t booth_decode(input logic n, input logic p1,
                                              input logic p0);
    booth_dig_t d;
    d.one = p1 ^ p0;
    d.two = (n & ~p1 & ~p0) | (~n & p1 & p0);
    d.neg = n & ~(p1 & p0);
    return d;
  endfunction

endpackage

// File: rtl/fam_sum_recoder.sv
`timescale 1ns/1ps
module fam_sum_recoder
  import fam_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0]           a_i,
  input  logic [N-1:0]           b_i,
  output booth_dig_t [N/2:0]     dig_o
);
  localparam int ND = N / 2 + 1;
  localparam int W  = N + 2;

  logic [W-1:0]  a_ext, b_ext;
  logic [ND-1:0] cin_fa, cin_bt;
  cell_out_t [ND-1:0] cells;
  logic [1:0] unused_top_carry;

  assign a_ext = {{2{a_i[N-1]}}, a_i};
  assign b_ext = {{2{b_i[N-1]}}, b_i};
  assign cin_fa[0] = 1'b0;
  assign cin_bt[0] = 1'b0;

  for (genvar j = 0; j < ND; j++) begin : g_cell
    assign cells[j] = sum_cell(a_ext[2*j], b_ext[2*j],
                               a_ext[2*j+1], b_ext[2*j+1], cin_fa[j]);
    assign dig_o[j] = booth_decode(cells[j].nbit, cells[j].pbit, cin_bt[j]);
    if (j < ND - 1) begin : g_link
      assign cin_fa[j+1] = cells[j].carry_fa;
      assign cin_bt[j+1] = cells[j].carry_bt;
    end
  end

  // Carries out of the top cell fall outside the representable range
  assign unused_top_carry = {cells[ND-1].carry_fa, cells[ND-1].carry_bt};
endmodule

// File: rtl/fam_pp_gen.sv
`timescale 1ns/1ps
module fam_pp_gen
  import fam_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0]             x_i,
  input  booth_dig_t [N/2:0]       dig_i,
  output logic [N/2+2:0][2*N:0]    rows_o
);
  localparam int ND = N / 2 + 1;
  localparam int ZW = 2 * N + 1;

  function automatic logic [ZW-1:0] sign_fix();
    logic [ZW-1:0] c;
    c = '0;
    for (int j = 0; j < ND; j++) c = c - (ZW'(1) << (N + 2 * j));
    return c;
  endfunction

  localparam logic [ZW-1:0] SIGN_FIX = sign_fix();

  logic [ZW-1:0] neg_row;

  for (genvar j = 0; j < ND; j++) begin : g_row
    logic [N:0] mag, flip;
    always_comb begin
      if (dig_i[j].two)      mag = {x_i, 1'b0};
      else if (dig_i[j].one) mag = {x_i[N-1], x_i};
      else                   mag = '0;
    end
    assign flip      = mag ^ {(N+1){dig_i[j].neg}};
    assign rows_o[j] = ZW'({~flip[N], flip[N-1:0]}) << (2 * j);
  end

  always_comb begin
    neg_row = '0;
    for (int j = 0; j < ND; j++) neg_row[2*j] = dig_i[j].neg;
  end

  assign rows_o[ND]   = neg_row;
  assign rows_o[ND+1] = SIGN_FIX;
endmodule

// File: rtl/fam_csa_tree.sv
`timescale 1ns/1ps
module fam_csa_tree #(
  parameter int W    = 33,
  parameter int ROWS = 11
) (
  input  logic [ROWS-1:0][W-1:0] rows_i,
  output logic [W-1:0]           sum_o,
  output logic [W-1:0]           carry_o
);
  localparam int PAD = ROWS + 2;

  function automatic logic [2*W-1:0] reduce(input logic [ROWS-1:0][W-1:0] r);
    logic [W-1:0] cur [PAD];
    logic [W-1:0] nxt [PAD];
    int cnt, ncnt;
    for (int i = 0; i < PAD; i++) cur[i] = (i < ROWS) ? r[i] : '0;
    cnt = ROWS;
    for (int lv = 0; lv < ROWS; lv++) begin
      ncnt = 0;
      for (int i = 0; i < PAD; i++) nxt[i] = '0;
      for (int g = 0; g < (ROWS + 2) / 3; g++) begin
        if (3 * g + 2 < cnt) begin
          nxt[ncnt]   = cur[3*g] ^ cur[3*g+1] ^ cur[3*g+2];
          nxt[ncnt+1] = ((cur[3*g] & cur[3*g+1]) | (cur[3*g] & cur[3*g+2]) |
                         (cur[3*g+1] & cur[3*g+2])) << 1;
          ncnt += 2;
        end else if (3 * g < cnt) begin
          nxt[ncnt] = cur[3*g];
          ncnt += 1;
          if (3 * g + 1 < cnt) begin
            nxt[ncnt] = cur[3*g+1];
            ncnt += 1;
          end
        end
      end
      for (int i = 0; i < PAD; i++) cur[i] = nxt[i];
      cnt = ncnt;
    end
    return {cur[1], cur[0]};
  endfunction

  assign {carry_o, sum_o} = reduce(rows_i);
endmodule

// File: rtl/fam_prefix_add.sv
`timescale 1ns/1ps
module fam_prefix_add #(
  parameter int W = 33
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);
  localparam int L = $clog2(W);

  logic [L:0][W-1:0] gg, pp;
  logic [W-1:0] unused_p_top;
  logic         unused_cout;

  assign gg[0] = a_i & b_i;
  assign pp[0] = a_i ^ b_i;

  for (genvar l = 0; l < L; l++) begin : g_lvl
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= (1 << l)) begin : g_comb
        assign gg[l+1][i] = gg[l][i] | (pp[l][i] & gg[l][i-(1<<l)]);
        assign pp[l+1][i] = pp[l][i] & pp[l][i-(1<<l)];
      end else begin : g_pass
        assign gg[l+1][i] = gg[l][i];
        assign pp[l+1][i] = pp[l][i];
      end
    end
  end

  assign s_o          = pp[0] ^ {gg[L][W-2:0], 1'b0};
  assign unused_p_top = pp[L];
  assign unused_cout  = gg[L][W-1];
endmodule

// File: rtl/fam_unit.sv
`timescale 1ns/1ps
module fam_unit
  import fam_pkg::*;
#(
  parameter int N       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   x,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N:0]   z
);
  localparam int ND   = N / 2 + 1;
  localparam int ZW   = 2 * N + 1;
  localparam int ROWS = ND + 2;

  booth_dig_t [ND-1:0]         dig;
  logic [ROWS-1:0][ZW-1:0]     rows;
  logic [ZW-1:0]               tree_sum, tree_carry, prod_comb;

  fam_sum_recoder #(.N(N)) u_rec (.a_i(a), .b_i(b), .dig_o(dig));
  fam_pp_gen      #(.N(N)) u_ppg (.x_i(x), .dig_i(dig), .rows_o(rows));
  fam_csa_tree    #(.W(ZW), .ROWS(ROWS)) u_tree (
    .rows_i(rows), .sum_o(tree_sum), .carry_o(tree_carry));
  fam_prefix_add  #(.W(ZW)) u_add (
    .a_i(tree_sum), .b_i(tree_carry), .s_o(prod_comb));

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) z <= '0;
      else        z <= prod_comb;
    end
  end else begin : g_comb
    assign z = prod_comb;
  end

  // Arithmetic restated behaviourally for the checks below
  function automatic logic [ZW-1:0] ref_prod(input logic [N-1:0] xv,
                                             input logic [N-1:0] av,
                                             input logic [N-1:0] bv);
    logic signed [ZW-1:0] xs, ys;
    xs = $signed({{(ZW-N){xv[N-1]}}, xv});
    ys = $signed({{(ZW-N){av[N-1]}}, av}) + $signed({{(ZW-N){bv[N-1]}}, bv});
    return xs * ys;
  endfunction

  function automatic logic [ZW-1:0] digit_total(input booth_dig_t [ND-1:0] d);
    logic [ZW-1:0] acc, t;
    acc = '0;
    for (int j = 0; j < ND; j++) begin
      t = d[j].two ? ZW'(2) : (d[j].one ? ZW'(1) : ZW'(0));
      if (d[j].neg) t = -t;
      acc = acc + (t << (2 * j));
    end
    return acc;
  endfunction

  function automatic logic [ZW-1:0] row_total(input logic [ROWS-1:0][ZW-1:0] r);
    logic [ZW-1:0] acc;
    acc = '0;
    for (int i = 0; i < ROWS; i++) acc = acc + r[i];
    return acc;
  endfunction

  for (genvar j = 0; j < ND; j++) begin : g_dchk
    // R3
    digit_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dig[j].one, dig[j].two}) && (!dig[j].neg || dig[j].one || dig[j].two));
  end

  // R3
  recode_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    digit_total(dig) == ({{(ZW-N){a[N-1]}}, a} + {{(ZW-N){b[N-1]}}, b}));

  // R7
  csa_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tree_sum + tree_carry) == row_total(rows));

  // R7
  row_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_total(rows) == ref_prod(x, a, b));

  // R1
  product_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_OUT && $past(rst_n)) |-> (z == $past(ref_prod(x, a, b))));

  // R2
  always @(posedge clk) begin
    if (!rst_n) reset_clear_chk: assert (z == '0);
  end
endmodule

// File: tb/test_fam_unit.sv
`timescale 1ns/1ps
module test_fam_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] x16 = '0, a16 = '0, b16 = '0;
  logic [32:0] z16;
  logic [3:0]  x4 = '0, a4 = '0, b4 = '0;
  logic [8:0]  z4;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fam_unit #(.N(16)) i_fam_unit (
    .clk(clk), .rst_n(rst_n), .x(x16), .a(a16), .b(b16), .z(z16));
  fam_unit #(.N(4)) i_fam_unit_n4 (
    .clk(clk), .rst_n(rst_n), .x(x4), .a(a4), .b(b4), .z(z4));

  // {x, a, b, expected z}
  localparam int NV = 12;
  localparam logic [80:0] VEC [NV] = '{
    {16'h0003, 16'h0004, 16'h0005, 33'h00000001B},
    {16'hFFFF, 16'h0001, 16'h0001, 33'h1FFFFFFFE},
    {16'h7FFF, 16'h7FFF, 16'h7FFF, 33'h07FFE0002},
    {16'h8000, 16'h8000, 16'h8000, 33'h080000000},
    {16'h8000, 16'h7FFF, 16'h7FFF, 33'h180010000},
    {16'h1234, 16'h0100, 16'hFF00, 33'h000000000},
    {16'h0000, 16'h5555, 16'h7FFF, 33'h000000000},
    {16'hFFFD, 16'hFFFB, 16'h0002, 33'h000000009},
    {16'h0002, 16'h8000, 16'hFFFF, 33'h1FFFEFFFE},
    {16'h0010, 16'h0100, 16'h0020, 33'h000001200},
    {16'h8000, 16'h0001, 16'h0000, 33'h1FFFF8000},
    {16'h7FFF, 16'h8000, 16'h8000, 33'h180010000}
  };
  localparam string VTAG [NV] = '{
    "R1", "R1", "R4", "R5", "R4", "R6", "R6", "R1", "R4", "R1", "R1", "R4"};

  function automatic logic [32:0] model16(input logic [15:0] xv,
                                          input logic [15:0] av,
                                          input logic [15:0] bv);
    longint xs, ys;
    xs = longint'($signed(xv));
    ys = longint'($signed(av)) + longint'($signed(bv));
    return 33'(xs * ys);
  endfunction

  function automatic logic [8:0] model4(input int xi, input int ai, input int bi);
    int xs, as, bs;
    xs = (xi > 7) ? xi - 16 : xi;
    as = (ai > 7) ? ai - 16 : ai;
    bs = (bi > 7) ? bi - 16 : bi;
    return 9'(xs * (as + bs));
  endfunction

  task automatic check(input string req, input logic [32:0] got,
                       input logic [32:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  initial begin
    logic [32:0] pend;
    // R2: outputs cleared while reset is held, inputs nonzero
    x16 = 16'h1234; a16 = 16'h0101; b16 = 16'h0202;
    x4 = 4'h5; a4 = 4'h3; b4 = 4'h2;
    repeat (3) @(negedge clk);
    check("R2", z16, 33'h0);
    check("R2", {24'h0, z4}, 33'h0);
    rst_n = 1'b1;

    // Directed table: R1 R4 R5 R6 (R3 R7 covered through the same products)
    for (int i = 0; i < NV; i++) begin
      {x16, a16, b16} = VEC[i][80:33];
      @(negedge clk);
      check(VTAG[i], z16, VEC[i][32:0]);
    end

    // R8: operands held steady, output holds
    x16 = 16'h4321; a16 = 16'h0F0F; b16 = 16'h00F1;
    @(negedge clk);
    pend = model16(x16, a16, b16);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8", z16, pend);
    end

    // R8 R1: back-to-back random operand sets, each result one cycle later
    x16 = 16'($urandom); a16 = 16'($urandom); b16 = 16'($urandom);
    pend = model16(x16, a16, b16);
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      check("R8", z16, pend);
      x16 = 16'($urandom); a16 = 16'($urandom); b16 = 16'($urandom);
      if (k % 7 == 0) a16 = 16'h8000;
      if (k % 11 == 0) b16 = 16'h7FFF;
      pend = model16(x16, a16, b16);
    end
    @(negedge clk);
    check("R1", z16, pend);

    // R1 R3 R7: exhaustive small width
    for (int xi = 0; xi < 16; xi++) begin
      for (int ai = 0; ai < 16; ai++) begin
        for (int bi = 0; bi < 16; bi++) begin
          x4 = 4'(xi); a4 = 4'(ai); b4 = 4'(bi);
          @(negedge clk);
          check("R1 R3 R7", {24'h0, z4}, {24'h0, model4(xi, ai, bi)});
        end
      end
    end

    // R2: asynchronous reset in the middle of traffic
    x16 = 16'h7FFF; a16 = 16'h7FFF; b16 = 16'h0001;
    @(negedge clk);
    check("R1", z16, model16(x16, a16, b16));
    rst_n = 1'b0;
    #1;
    check("R2", z16, 33'h0);
    @(negedge clk);
    check("R2", z16, 33'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", z16, model16(x16, a16, b16));

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule